// File: doc/BRIEF.md
# Flash Block-Erase Command Controller

This block sits between a simple bus and a small NOR-style flash array model. It decodes byte-wide command writes, holds an 8-bit status register, and runs a guarded block erase. An erase needs two writes in a row: a setup code, then a confirm code whose address picks the block. A counter stands in for the erase engine. While it runs, the block asks an external array port to fill the chosen block with ones. The erase can be paused and resumed. Error bits stay set until software clears them with a dedicated command.

The state machine has five named states. ST_READY is idle and decodes commands. ST_SETUP means a setup code was seen and the next write is judged as the confirm. ST_BUSY means the erase is counting. ST_SUSP_PEND means a pause was asked for and a latency counter is running. ST_SUSPENDED means the erase is frozen. The transitions are:
- ST_READY to ST_SETUP on 20h.
- ST_SETUP to ST_BUSY on an accepted D0h.
- ST_SETUP to ST_READY on any other write, or on a refused D0h.
- ST_BUSY to ST_SUSP_PEND on B0h.
- ST_BUSY to ST_READY when the count ends.
- ST_SUSP_PEND to ST_BUSY on D0h.
- ST_SUSP_PEND to ST_SUSPENDED when the latency expires.
- ST_SUSP_PEND to ST_READY when the count ends first.
- ST_SUSPENDED to ST_BUSY on D0h.

A separate read-mode flag picks whether reads return array data or status.

Status byte layout: bit 7 is ready, bit 6 is suspended, bit 5 is erase error, bit 4 is sequence error, bit 3 is VPP error, and bits 2..0 are always 0. Codes: FFh read array, 70h read status, 50h clear errors, 20h erase setup, D0h confirm/resume, B0h suspend. The block index is bus_addr[ADDR_W-1:OFS_W].

Top module: `flash_erase_ctrl`

## Requirements
- R1: After reset the block is in ST_READY with array-read mode selected, and the status byte is 80h (bits 2..0 are 0 at all times).
- R2: An erase starts only when 20h is written and the very next write is D0h. The setup write's address is ignored, and the confirm write's address selects the block.
- R3: While the erase counts, every read returns the status byte with bit 7 at 0, and every write except B0h is ignored.
- R4: After ERASE_CYCLES counting clocks the block returns to ST_READY in status-read mode (status 80h). Every byte of the selected block then reads FFh, and other blocks are unchanged.
- R5: A write other than D0h after 20h sets bits 4 and 5, starts no erase, and selects status-read mode.
- R6: If vpp_ok is low when D0h confirms, bits 3 and 5 are set and no erase starts.
- R7: Bits 3, 4 and 5 stay set through any other command and are cleared only by writing 50h.
- R8: While bit 3 is set, a confirm is refused and no erase starts.
- R9: B0h during an erase takes effect SUSPEND_LATENCY clocks later, giving status C0h. The remaining count is held while suspended.
- R10: In ST_SUSPENDED, FFh, 70h and D0h are accepted. In array mode, reads outside the suspended block return array data, and reads inside it return the status byte. D0h resumes the erase.
- R11: D0h written before the suspend takes effect continues the erase directly, and status bit 6 is never set.
- R12: FFh selects array-read mode and 70h selects status-read mode whenever the block is in ST_READY or ST_SUSPENDED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Command write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Command code |
| vpp_ok | input | 1 | Program/erase supply is valid |
| rd_valid | output | 1 | Read data valid, one clock after bus_rd |
| rd_data | output | 8 | Read data (array or status) |
| arr_addr | output | ADDR_W | Array read address |
| arr_rdata | input | 8 | Array read data for arr_addr |
| fill_req | output | 1 | Request to fill block fill_blk with ones |
| fill_blk | output | ADDR_W-OFS_W | Block being erased |

## Verification
The hardest case to reach from the ports is a resume that arrives inside the few clocks between a suspend request and its effect. The stimulus issues B0h in the middle of a running erase and writes D0h on the very next bus cycle. It then reads status several clocks later and expects 00h rather than C0h. A second hard case is showing that the count is held across a long suspension. The bench parks the erase for far longer than ERASE_CYCLES, checks that status still reports suspended, and after resuming checks that the erase is still busy before it later completes.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_READY,
        ST_SETUP,
        ST_BUSY,
        ST_SUSP_PEND,
        ST_SUSPENDED
    } fsm_state_t;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_READ_ARRAY,
        CMD_READ_STATUS,
        CMD_CLEAR,
        CMD_SETUP,
        CMD_CONFIRM,
        CMD_SUSPEND
    } cmd_t;

    localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] OP_READ_STATUS = 8'h70;
    localparam logic [7:0] OP_CLEAR       = 8'h50;
    localparam logic [7:0] OP_SETUP       = 8'h20;
    localparam logic [7:0] OP_CONFIRM     = 8'hD0;
    localparam logic [7:0] OP_SUSPEND     = 8'hB0;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic [7:0] code,
    output cmd_t       cmd
);
    always_comb begin
        case (code)
            OP_READ_ARRAY:  cmd = CMD_READ_ARRAY;
            OP_READ_STATUS: cmd = CMD_READ_STATUS;
            OP_CLEAR:       cmd = CMD_CLEAR;
            OP_SETUP:       cmd = CMD_SETUP;
            OP_CONFIRM:     cmd = CMD_CONFIRM;
            OP_SUSPEND:     cmd = CMD_SUSPEND;
            default:        cmd = CMD_NONE;
        endcase
    end
endmodule

// File: rtl/flash_down_counter.sv
module flash_down_counter #(
    parameter int LOAD = 64,
    localparam int W = $clog2(LOAD + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         en,
    output logic [W-1:0] count,
    output logic         last
);
    localparam logic [W-1:0] LOAD_V = W'(LOAD);
    localparam logic [W-1:0] ONE_V  = W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= LOAD_V;
        end else if (en && count != '0) begin
            count <= count - ONE_V;
        end
    end

    assign last = en && (count == ONE_V);
endmodule

// File: rtl/flash_status_bits.sv
module flash_status_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic set_vpp,
    input  logic set_seq,
    input  logic set_erase,
    input  logic clear,
    output logic vpp_err,
    output logic seq_err,
    output logic erase_err
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpp_err   <= 1'b0;
            seq_err   <= 1'b0;
            erase_err <= 1'b0;
        end else if (clear) begin
            vpp_err   <= 1'b0;
            seq_err   <= 1'b0;
            erase_err <= 1'b0;
        end else begin
            if (set_vpp)   vpp_err   <= 1'b1;
            if (set_seq)   seq_err   <= 1'b1;
            if (set_erase) erase_err <= 1'b1;
        end
    end

    // a VPP fault is never reported without the erase fault beside it (R6)
    assert_vpp_pairs_erase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_err |-> erase_err);
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W          = 8,
    parameter int OFS_W           = 4,
    parameter int ERASE_CYCLES    = 64,
    parameter int SUSPEND_LATENCY = 4,
    localparam int BLK_W          = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              vpp_ok,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [7:0]        arr_rdata,
    output logic              fill_req,
    output logic [BLK_W-1:0]  fill_blk
);
    localparam int ECNT_W = $clog2(ERASE_CYCLES + 1);
    localparam int LCNT_W = $clog2(SUSPEND_LATENCY + 1);

    fsm_state_t       state, state_n;
    logic             stat_mode, stat_mode_n;
    logic [BLK_W-1:0] erase_blk, erase_blk_n;
    cmd_t             cmd;

    logic              load_erase, load_lat;
    logic              erase_en, lat_en;
    logic              erase_last, lat_last;
    logic [ECNT_W-1:0] erase_cnt;
    logic [LCNT_W-1:0] lat_cnt;

    logic set_vpp, set_seq, set_erase, clr_err;
    logic vpp_err, seq_err, erase_err;
    logic sr_ready, sr_susp;
    logic [7:0] status;
    logic [BLK_W-1:0] addr_blk;

    assign addr_blk = bus_addr[ADDR_W-1:OFS_W];

    flash_cmd_decode u_decode (
        .code (bus_wdata),
        .cmd  (cmd)
    );

    flash_down_counter #(.LOAD(ERASE_CYCLES)) u_erase_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_erase),
        .en    (erase_en),
        .count (erase_cnt),
        .last  (erase_last)
    );

    flash_down_counter #(.LOAD(SUSPEND_LATENCY)) u_lat_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_lat),
        .en    (lat_en),
        .count (lat_cnt),
        .last  (lat_last)
    );

    flash_status_bits u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vpp   (set_vpp),
        .set_seq   (set_seq),
        .set_erase (set_erase),
        .clear     (clr_err),
        .vpp_err   (vpp_err),
        .seq_err   (seq_err),
        .erase_err (erase_err)
    );

    assign erase_en = (state == ST_BUSY) || (state == ST_SUSP_PEND);
    assign lat_en   = (state == ST_SUSP_PEND);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_READY;
            stat_mode <= 1'b0;
            erase_blk <= '0;
        end else begin
            state     <= state_n;
            stat_mode <= stat_mode_n;
            erase_blk <= erase_blk_n;
        end
    end

    // next state and control strobes
    always_comb begin
        state_n     = state;
        stat_mode_n = stat_mode;
        erase_blk_n = erase_blk;
        load_erase  = 1'b0;
        load_lat    = 1'b0;
        set_vpp     = 1'b0;
        set_seq     = 1'b0;
        set_erase   = 1'b0;
        clr_err     = 1'b0;
        unique case (state)
            ST_READY: begin
                if (bus_we) begin
                    case (cmd)
                        CMD_READ_ARRAY:  stat_mode_n = 1'b0;
                        CMD_READ_STATUS: stat_mode_n = 1'b1;
                        CMD_CLEAR:       clr_err     = 1'b1;
                        CMD_SETUP:       state_n     = ST_SETUP;
                        default:         ;
                    endcase
                end
            end
            ST_SETUP: begin
                if (bus_we) begin
                    stat_mode_n = 1'b1;
                    state_n     = ST_READY;
                    if (cmd != CMD_CONFIRM) begin
                        set_seq   = 1'b1;
                        set_erase = 1'b1;
                    end else if (vpp_err) begin
                        set_erase = 1'b1;
                    end else if (!vpp_ok) begin
                        set_vpp   = 1'b1;
                        set_erase = 1'b1;
                    end else begin
                        state_n     = ST_BUSY;
                        load_erase  = 1'b1;
                        erase_blk_n = addr_blk;
                    end
                end
            end
            ST_BUSY: begin
                stat_mode_n = 1'b1;
                if (erase_last) begin
                    state_n = ST_READY;
                end else if (bus_we && cmd == CMD_SUSPEND) begin
                    state_n  = ST_SUSP_PEND;
                    load_lat = 1'b1;
                end
            end
            ST_SUSP_PEND: begin
                stat_mode_n = 1'b1;
                if (erase_last) begin
                    state_n = ST_READY;
                end else if (bus_we && cmd == CMD_CONFIRM) begin
                    state_n = ST_BUSY;
                end else if (lat_last) begin
                    state_n = ST_SUSPENDED;
                end
            end
            ST_SUSPENDED: begin
                if (bus_we) begin
                    case (cmd)
                        CMD_READ_ARRAY:  stat_mode_n = 1'b0;
                        CMD_READ_STATUS: stat_mode_n = 1'b1;
                        CMD_CONFIRM: begin
                            state_n     = ST_BUSY;
                            stat_mode_n = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            default: state_n = ST_READY;
        endcase
    end

    // outputs
    always_comb begin
        sr_ready = !((state == ST_BUSY) || (state == ST_SUSP_PEND));
        sr_susp  = (state == ST_SUSPENDED);
        status   = {sr_ready, sr_susp, erase_err, seq_err, vpp_err, 3'b000};
        fill_req = erase_en;
        fill_blk = erase_blk;
        arr_addr = bus_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= bus_rd;
            if (bus_rd) begin
                if (stat_mode || (sr_susp && addr_blk == erase_blk)) begin
                    rd_data <= status;
                end else begin
                    rd_data <= arr_rdata;
                end
            end
        end
    end

    assert_busy_reads_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && state == ST_BUSY) |=> (rd_valid && rd_data[7] == 1'b0));

    assert_fill_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> !status[7]);

    assert_vpp_refuses_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETUP && bus_we && bus_wdata == OP_CONFIRM && !vpp_ok)
        |=> (state == ST_READY && vpp_err && erase_err));

    assert_sticky_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(erase_err) |-> $past(bus_we && bus_wdata == OP_CLEAR));

    assert_count_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSPENDED && $past(state == ST_SUSPENDED)) |-> $stable(erase_cnt));

    assert_suspend_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSPENDED && $past(state) != ST_SUSPENDED)
        |-> $past(state) == ST_SUSP_PEND);

    assert_latency_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSP_PEND) |-> lat_cnt != '0);

    assert_low_bits_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!stat_mode || rd_data[2:0] == 3'b000));
endmodule

// File: tb/flash_erase_ctrl_tb.sv
`timescale 1ns/1ps
module flash_erase_ctrl_tb;
    localparam int ADDR_W = 8;
    localparam int OFS_W  = 4;
    localparam int BLK_W  = ADDR_W - OFS_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic              vpp_ok = 1'b1;
    logic              rd_valid;
    logic [7:0]        rd_data;
    logic [ADDR_W-1:0] arr_addr;
    logic [7:0]        arr_rdata;
    logic              fill_req;
    logic [BLK_W-1:0]  fill_blk;

    logic [7:0] mem [0:(1<<ADDR_W)-1];

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    flash_erase_ctrl #(.ADDR_W(ADDR_W), .OFS_W(OFS_W),
                       .ERASE_CYCLES(64), .SUSPEND_LATENCY(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .vpp_ok(vpp_ok),
        .rd_valid(rd_valid), .rd_data(rd_data), .arr_addr(arr_addr),
        .arr_rdata(arr_rdata), .fill_req(fill_req), .fill_blk(fill_blk)
    );

    // array model
    assign arr_rdata = mem[arr_addr];
    always @(posedge clk) begin
        if (fill_req) begin
            for (int o = 0; o < (1 << OFS_W); o++) begin
                mem[{fill_blk, OFS_W'(o)}] <= 8'hFF;
            end
        end
    end

    function automatic logic [7:0] pat(input int a);
        return 8'(a) ^ 8'hA5;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected read: actual %02h expected none", rd_data);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual %02h expected %02h", t, rd_data, e);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = pat(i);
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        rd(8'h07, pat(8'h07), "R1 array mode after reset");
        wr(8'h00, 8'h70);
        rd(8'h00, 8'h80, "R1 status after reset");
        wr(8'h00, 8'hFF);

        // R2/R3/R4: erase block 2, setup address elsewhere
        wr(8'hF0, 8'h20);
        wr(8'h25, 8'hD0);
        rd(8'h25, 8'h00, "R3 busy status");
        wr(8'h00, 8'hFF);
        rd(8'h10, 8'h00, "R3 FFh ignored while busy");
        idle(80);
        rd(8'h10, 8'h80, "R4 done status mode");
        wr(8'h00, 8'hFF);
        rd(8'h20, 8'hFF, "R4 block start erased");
        rd(8'h2F, 8'hFF, "R2 R4 block end erased");
        rd(8'h30, pat(8'h30), "R4 next block intact");
        rd(8'hF1, pat(8'hF1), "R2 setup address not erased");

        // R5/R7: bad confirm on block 3
        wr(8'h33, 8'h20);
        wr(8'h33, 8'h40);
        rd(8'h33, 8'hB0, "R5 bad confirm status");
        wr(8'h00, 8'hFF);
        rd(8'h33, pat(8'h33), "R5 no erase");
        wr(8'h00, 8'h70);
        rd(8'h00, 8'hB0, "R7 bits sticky");
        wr(8'h00, 8'h50);
        rd(8'h00, 8'h80, "R7 cleared by 50h");

        // R6/R8: VPP error then refusal
        vpp_ok = 1'b0;
        wr(8'h00, 8'h20);
        wr(8'h45, 8'hD0);
        rd(8'h45, 8'hA8, "R6 vpp error status");
        idle(80);
        wr(8'h00, 8'hFF);
        rd(8'h45, pat(8'h45), "R6 no erase");
        vpp_ok = 1'b1;
        wr(8'h00, 8'h20);
        wr(8'h45, 8'hD0);
        rd(8'h45, 8'hA8, "R8 confirm refused");
        idle(80);
        wr(8'h00, 8'hFF);
        rd(8'h46, pat(8'h46), "R8 no erase");
        wr(8'h00, 8'h50);
        wr(8'h00, 8'h70);
        rd(8'h00, 8'h80, "R7 clear after vpp");

        // R9/R10: suspend and resume block 5
        wr(8'h50, 8'h20);
        wr(8'h50, 8'hD0);
        idle(10);
        wr(8'h00, 8'hB0);
        rd(8'h00, 8'h00, "R9 pending still busy");
        idle(6);
        rd(8'h00, 8'hC0, "R9 suspended status");
        wr(8'h00, 8'hFF);
        rd(8'h10, pat(8'h10), "R10 outside block array data");
        rd(8'h52, 8'hC0, "R10 inside block returns status");
        idle(100);
        wr(8'h00, 8'h70);
        rd(8'h00, 8'hC0, "R9 count held in suspend");
        wr(8'h00, 8'hD0);
        rd(8'h00, 8'h00, "R10 resumed busy");
        idle(100);
        rd(8'h00, 8'h80, "R4 resumed erase done");
        wr(8'h00, 8'hFF);
        rd(8'h5F, 8'hFF, "R4 block 5 erased");

        // R11: resume before suspend takes effect
        wr(8'h00, 8'h20);
        wr(8'h61, 8'hD0);
        idle(5);
        wr(8'h00, 8'hB0);
        wr(8'h00, 8'hD0);
        idle(8);
        rd(8'h00, 8'h00, "R11 no suspend entered");
        idle(80);
        rd(8'h00, 8'h80, "R11 erase completed");

        // R12: mode commands
        wr(8'h00, 8'hFF);
        rd(8'h61, 8'hFF, "R12 array mode after FFh");
        rd(8'h71, pat(8'h71), "R12 array data");
        wr(8'h00, 8'h70);
        rd(8'h71, 8'h80, "R12 status mode after 70h");

        idle(4);
        finish_run();
    end
endmodule